// File: doc/BRIEF.md
# Reset Exception Sequencer

This block gathers every cause of a system reset for a small processor into one reset state, then brings the processor back up in a fixed order. There are two hard reset causes. One is an active-low pin that acts at once, with no clock needed. The other is a single-cycle overflow pulse from a timer running as a watchdog. A stop-mode clear input is also tracked. While it is held low the block stays in the reset state, and after it is released the oscillator is given time to settle.

While the block is in the reset state it drives three outputs high: an initialize strobe for the processor and peripheral registers, a clear for the RAM-enable flag, and a clear for the interrupt-enable flag. The outputs that allow execution stay low. On leaving reset, the block pulses a program counter load for one cycle with the reset vector. Instruction fetch is enabled on the next cycle.

The release of the pin and of stop-clear passes through two-flop synchronizers. After a pin reset or a stop clear, the block waits for a stabilization count before it loads the program counter. After a watchdog overflow it waits only for a minimum hold of two instruction cycles.

Top module: `rst_seq`

## Requirements
- R1: While `rst_pin_n` is low, `sys_init`, `ram_en_clr` and `irq_en_clr` are 1 and `pc_load` and `fetch_en` are 0. This takes effect at once, with no clock edge. The three clear/initialize outputs are always equal.
- R2: When `rst_pin_n` is released between clock edges, `pc_load` is first 1 after the (STAB_CYCLES+2)-th rising edge that follows. It stays 1 for exactly one cycle.
- R3: While `pc_load` is 1, `pc_value` equals RESET_VEC, which defaults to 0x0000. Otherwise `pc_value` is 0.
- R4: `fetch_en` is 0 during the whole reset state. It becomes 1 in the cycle after the `pc_load` cycle and stays 1 until the next reset.
- R5: A one-cycle `wdt_ovf` pulse during normal run is sampled at a rising edge, and the reset state starts from that edge. `pc_load` is first 1 after CYC_PER_INSN*MIN_INSNS+1 rising edges, counting the sampling edge.
- R6: A `wdt_ovf` pulse that arrives while the block is already in the reset state has no effect on when `pc_load` occurs.
- R7: When `stop_clr_n` goes low, the reset outputs are active after at most three rising edges and stay active while it is held low. After it is released, `pc_load` follows after STAB_CYCLES+2 rising edges.
- R8: A pin reset has priority over everything else. If the pin goes low during a watchdog hold, the hold restarts and the full stabilization count applies after the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| wdt_ovf | input | 1 | One-cycle watchdog overflow pulse |
| stop_clr_n | input | 1 | Active-low stop-mode clear request |
| sys_init | output | 1 | Initialize strobe to processor and peripheral registers |
| ram_en_clr | output | 1 | Clears the RAM-enable flag |
| irq_en_clr | output | 1 | Clears the interrupt-enable flag |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_value | output | PC_W | Value loaded into the program counter |
| fetch_en | output | 1 | Instruction fetch enable |

## Verification
Some properties are checked by assertions on every cycle:
- the clear and initialize outputs stay equal;
- `fetch_en` is never high while initialize is active;
- the load strobe lasts one cycle, carries the vector and is always followed by `fetch_en`;
- a watchdog pulse seen during run always leads to the reset state on the next cycle.

The exact release latencies can only be shown by the bench scenarios. These are the stabilization count after a pin or stop-clear release and the short hold after a watchdog overflow. The same goes for the immediate, clockless effect of the pin, the fact that watchdog pulses during reset are ignored, and a pin reset restarting a watchdog hold.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int CYC_PER_INSN = 2,
  parameter int MIN_INSNS    = 2,
  parameter int STAB_CYCLES  = 32,
  parameter int PC_W         = 16,
  parameter int RESET_VEC    = 0
) (
  input  logic            clk,
  input  logic            rst_pin_n,
  input  logic            wdt_ovf,
  input  logic            stop_clr_n,
  output logic            sys_init,
  output logic            ram_en_clr,
  output logic            irq_en_clr,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_value,
  output logic            fetch_en
);
  localparam int HOLD_CYC = CYC_PER_INSN * MIN_INSNS;
  localparam int MAX_WAIT = (STAB_CYCLES > HOLD_CYC) ? STAB_CYCLES : HOLD_CYC;
  localparam int CW       = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] STAB_M1 = CW'(STAB_CYCLES - 1);
  localparam logic [CW-1:0] HOLD_M1 = CW'(HOLD_CYC - 1);
  localparam logic [PC_W-1:0] VEC   = PC_W'(RESET_VEC);

  typedef enum logic [1:0] {S_HOLD, S_LOAD, S_RUN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          long_wait;
  logic          rel1, rel2, stp1, stp2;
  logic [CW-1:0] need_m1;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      rel1 <= 1'b0;
      rel2 <= 1'b0;
      stp1 <= 1'b1;
      stp2 <= 1'b1;
    end else begin
      rel1 <= 1'b1;
      rel2 <= rel1;
      stp1 <= stop_clr_n;
      stp2 <= stp1;
    end

  assign need_m1 = long_wait ? STAB_M1 : HOLD_M1;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      state     <= S_HOLD;
      cnt       <= '0;
      long_wait <= 1'b1;
    end else begin
      case (state)
        S_HOLD:
          if (!stp2) begin
            cnt       <= '0;
            long_wait <= 1'b1;
          end else if (rel2) begin
            if (cnt == need_m1) begin
              state <= S_LOAD;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        default:
          if (!stp2) begin
            state     <= S_HOLD;
            cnt       <= '0;
            long_wait <= 1'b1;
          end else if (wdt_ovf) begin
            state     <= S_HOLD;
            cnt       <= '0;
            long_wait <= 1'b0;
          end else begin
            state <= S_RUN;
          end
      endcase
    end

  assign sys_init   = (state == S_HOLD);
  assign ram_en_clr = sys_init;
  assign irq_en_clr = sys_init;
  assign pc_load    = (state == S_LOAD);
  assign pc_value   = pc_load ? VEC : '0;
  assign fetch_en   = (state == S_RUN);
endmodule

module rst_seq_chk #(
  parameter int PC_W      = 16,
  parameter int RESET_VEC = 0
) (
  input logic            clk,
  input logic            rst_pin_n,
  input logic            wdt_ovf,
  input logic            sys_init,
  input logic            ram_en_clr,
  input logic            irq_en_clr,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_value,
  input logic            fetch_en
);
  a_r1_flags_together: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (ram_en_clr == sys_init) && (irq_en_clr == sys_init));
  a_r4_no_fetch_in_init: assert property (@(posedge clk) disable iff (!rst_pin_n)
    sys_init |-> !fetch_en && !pc_load);
  a_r2_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pc_load |=> !pc_load);
  a_r3_vector: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pc_load |-> pc_value == PC_W'(RESET_VEC));
  a_r4_fetch_follows_load: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (pc_load && !wdt_ovf) |=> fetch_en || sys_init);
  a_r5_wdt_enters_reset: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (fetch_en && wdt_ovf) |=> sys_init);
  a_r5_min_hold: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(sys_init) |=> sys_init);
endmodule

bind rst_seq rst_seq_chk #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .sys_init(sys_init),
  .ram_en_clr(ram_en_clr), .irq_en_clr(irq_en_clr), .pc_load(pc_load),
  .pc_value(pc_value), .fetch_en(fetch_en)
);

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int PERIOD = 10;
  localparam int CPI    = 2;
  localparam int MINI   = 2;
  localparam int STAB   = 32;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, wdt_ovf = 1'b0, stop_clr_n = 1'b1;
  logic sys_init, ram_en_clr, irq_en_clr, pc_load, fetch_en;
  logic [15:0] pc_value;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rst_seq #(.CYC_PER_INSN(CPI), .MIN_INSNS(MINI), .STAB_CYCLES(STAB)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .stop_clr_n(stop_clr_n),
    .sys_init(sys_init), .ram_en_clr(ram_en_clr), .irq_en_clr(irq_en_clr),
    .pc_load(pc_load), .pc_value(pc_value), .fetch_en(fetch_en));

  function automatic int exp_cold();
    return STAB + 2;
  endfunction
  function automatic int exp_wdt();
    return CPI * MINI + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk_reset_outs(input string req);
    chk(sys_init && ram_en_clr && irq_en_clr && !pc_load && !fetch_en, req,
        {sys_init, ram_en_clr, irq_en_clr, pc_load, fetch_en}, 5'b11100);
  endtask

  // counts rising edges until pc_load is seen; wdt_ovf cleared each negedge,
  // re-pulsed when the edge count equals extra_at
  task automatic measure(input int extra_at, output int edges);
    bit early_fetch = 0;
    edges = 0;
    while (1) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      wdt_ovf = (edges == extra_at);
      if (pc_load) break;
      if (fetch_en) early_fetch = 1;
      if (edges > 5000) break;
    end
    wdt_ovf = 0;
    chk(!early_fetch, "R4 fetch low in reset", early_fetch, 0);
    chk(pc_value == 16'h0000, "R3 vector on load", pc_value, 0);
    @(negedge clk);
    chk(fetch_en && !pc_load, "R4 fetch after load", {fetch_en, pc_load}, 2'b10);
  endtask

  task automatic do_pin(input int extra_at, input string req);
    int e;
    @(negedge clk);
    rst_pin_n = 0;
    #1 chk_reset_outs("R1 async entry");
    repeat (1 + $urandom % 4) @(negedge clk);
    rst_pin_n = 1;
    measure(extra_at, e);
    chk(e == exp_cold(), req, e, exp_cold());
  endtask

  task automatic do_wdt(input int extra_at, input string req);
    int e;
    @(negedge clk);
    wdt_ovf = 1;
    measure(extra_at, e);
    chk(e == exp_wdt(), req, e, exp_wdt());
  endtask

  task automatic do_stop(input int hold);
    int e;
    @(negedge clk);
    stop_clr_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_outs("R7 stop entry");
    repeat (hold) @(negedge clk);
    chk(sys_init, "R7 held", sys_init, 1);
    stop_clr_n = 1;
    measure(-1, e);
    chk(e == exp_cold(), "R7 stop release", e, exp_cold());
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
    finish_up();
  end

  initial begin
    int e;
    void'($urandom(32'd4242));
    #2 chk_reset_outs("R1 reset state before clock");
    repeat (3) @(negedge clk);
    rst_pin_n = 1;
    measure(-1, e);
    chk(e == exp_cold(), "R2 cold release", e, exp_cold());
    repeat (5) @(negedge clk);
    chk(fetch_en, "R4 fetch stays high", fetch_en, 1);

    do_wdt(-1, "R5 watchdog hold");
    do_wdt(2, "R6 wdt during hold ignored");
    do_pin(10, "R6 wdt during stabilization ignored");
    do_stop(7);

    // R8: pin reset during a watchdog hold
    @(negedge clk);
    wdt_ovf = 1;
    @(negedge clk);
    wdt_ovf = 0;
    @(posedge clk);
    #1 rst_pin_n = 0;
    #1 chk_reset_outs("R1 mid-cycle async");
    @(negedge clk);
    rst_pin_n = 1;
    measure(-1, e);
    chk(e == exp_cold(), "R8 pin restarts hold", e, exp_cold());

    for (int i = 0; i < 12; i++) begin
      int k = $urandom % 3;
      repeat ($urandom % 6) @(negedge clk);
      case (k)
        0: do_pin(-1, "R2 random pin");
        1: do_wdt(($urandom % 2) ? 1 + $urandom % 3 : -1, "R5 random watchdog");
        default: do_stop(1 + $urandom % 10);
      endcase
    end
    finish_up();
  end
endmodule